// File: doc/BRIEF.md
# Dual-Core Reset Scope Controller

This block maps reset events in a two-core system onto two reset outputs: one for the primary core and one for the secondary core. A device-level event resets both cores. A device-level event is an external reset request, a primary NMI-watchdog expiry or a primary watchdog expiry. An event raised by the secondary core resets that core only. A secondary-core event is an NMI-watchdog expiry, or a watchdog expiry while its enable bit is set. Each reset output stays asserted for at least `HOLD_CYC` clocks.

After power-on or any device-level reset, the secondary core stays held in reset until the primary core issues a release. A reset local to the secondary core ends by itself when its hold time runs out. A local reset neither arms the hold nor clears it. When the secondary NMI watchdog causes the reset, the primary core receives a one-cycle NMI pulse. Three sticky flags record what happened. The primary core clears them with a clear strobe.

All event, release and clear inputs are single-cycle strobes sampled on the rising clock edge. Their effect appears at the outputs after that edge. The asynchronous power-on reset `rst_n` asserts both reset outputs at once. It is released synchronously.

Top module: `dcore_rst_scope`

## Requirements
- R1: A cycle with `dev_rst_req` high asserts both `p_rst` and `s_rst` from the next edge.
- R2: A cycle with `p_nmiwd_exp` high asserts both `p_rst` and `s_rst` from the next edge and sets `flag_dev`.
- R3: A cycle with `p_wd_exp` high asserts both `p_rst` and `s_rst` from the next edge and sets `flag_dev`.
- R4: An accepted `s_nmiwd_exp` asserts `s_rst` for `HOLD_CYC` cycles and leaves `p_rst` low. It is accepted when no device event occurs in the same cycle and `p_rst` is low.
- R5: An accepted `s_nmiwd_exp` raises `p_nmi` for exactly one cycle, in the first cycle that `s_rst` is high for that event, and sets `flag_s_nmiwd`.
- R6: `s_wd_exp` asserts `s_rst` and sets `flag_s_wd` only when `s_wd_rst_en` is 1. With `s_wd_rst_en` at 0 it changes no output.
- R7: After `rst_n` or any device-level event, `s_rst` stays high until `s_release` is strobed while `p_rst` is low. A release strobed while `p_rst` is high is ignored.
- R8: A secondary-local reset deasserts after `HOLD_CYC` cycles without any release. If the hold from a device reset is still armed, `s_rst` stays high until a release.
- R9: Every assertion of `p_rst` or `s_rst` lasts at least `HOLD_CYC` cycles. `rst_n` low asserts both outputs asynchronously.
- R10: The flags stay set until `flag_clr`. A set in the same cycle as the clear wins. Device-level resets do not clear the flags, and only `rst_n` resets them to 0.
- R11: When a device event and a secondary event arrive in the same cycle, the device reset is taken. The secondary flag is not set, `p_nmi` stays low, and the secondary core waits for a release.
- R12: `s_release` while `s_rst` is already low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| dev_rst_req | input | 1 | Device reset request strobe |
| p_nmiwd_exp | input | 1 | Primary NMI-watchdog expiry strobe |
| p_wd_exp | input | 1 | Primary watchdog expiry strobe |
| s_nmiwd_exp | input | 1 | Secondary NMI-watchdog expiry strobe |
| s_wd_exp | input | 1 | Secondary watchdog expiry strobe |
| s_wd_rst_en | input | 1 | Lets the secondary watchdog reset the secondary core |
| s_release | input | 1 | Release strobe from the primary core |
| flag_clr | input | 1 | Clears all cause flags |
| p_rst | output | 1 | Primary core reset, active high |
| s_rst | output | 1 | Secondary core reset, active high |
| p_nmi | output | 1 | One-cycle NMI to the primary core for a secondary NMI-watchdog reset |
| flag_dev | output | 1 | Sticky: device-level reset occurred |
| flag_s_nmiwd | output | 1 | Sticky: secondary NMI-watchdog reset occurred |
| flag_s_wd | output | 1 | Sticky: secondary watchdog reset occurred |

## Verification
The block holds three pieces of state: two hold counters and the armed-hold bit. Each fault shows at the ports within a few cycles. A lost armed bit lets `s_rst` fall right after a device reset, without waiting for a release. A counter that loads or decrements wrongly moves the falling edge of a reset away from exactly `HOLD_CYC` cycles, and the edge-timed vectors catch that shift. A faulty priority or acceptance decision shows up in the cycle after the event, as a wrong reset scope, a stray `p_nmi` or a wrongly set flag.

// File: rtl/dcore_rst_scope.sv
module dcore_rst_scope #(
  parameter int HOLD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_rst_req,
  input  logic p_nmiwd_exp,
  input  logic p_wd_exp,
  input  logic s_nmiwd_exp,
  input  logic s_wd_exp,
  input  logic s_wd_rst_en,
  input  logic s_release,
  input  logic flag_clr,
  output logic p_rst,
  output logic s_rst,
  output logic p_nmi,
  output logic flag_dev,
  output logic flag_s_nmiwd,
  output logic flag_s_wd
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

  logic [CW-1:0] p_cnt, s_cnt;
  logic          s_armed;
  logic          dev_evt, s_nmi_ok, s_wd_ok, s_evt, rel_ok;

  assign dev_evt  = dev_rst_req | p_nmiwd_exp | p_wd_exp;
  assign s_nmi_ok = s_nmiwd_exp & ~dev_evt & ~p_rst;
  assign s_wd_ok  = s_wd_exp & s_wd_rst_en & ~dev_evt & ~p_rst;
  assign s_evt    = s_nmi_ok | s_wd_ok;
  assign rel_ok   = s_release & ~p_rst & ~dev_evt;

  assign p_rst = (p_cnt != '0);
  assign s_rst = (s_cnt != '0) | s_armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                p_cnt <= HOLD_V;
    else if (dev_evt)          p_cnt <= HOLD_V;
    else if (p_cnt != '0)      p_cnt <= p_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                s_cnt <= HOLD_V;
    else if (dev_evt || s_evt) s_cnt <= HOLD_V;
    else if (s_cnt != '0)      s_cnt <= s_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       s_armed <= 1'b1;
    else if (dev_evt) s_armed <= 1'b1;
    else if (rel_ok)  s_armed <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p_nmi        <= 1'b0;
      flag_dev     <= 1'b0;
      flag_s_nmiwd <= 1'b0;
      flag_s_wd    <= 1'b0;
    end else begin
      p_nmi        <= s_nmi_ok;
      flag_dev     <= dev_evt  | (flag_dev     & ~flag_clr);
      flag_s_nmiwd <= s_nmi_ok | (flag_s_nmiwd & ~flag_clr);
      flag_s_wd    <= s_wd_ok  | (flag_s_wd    & ~flag_clr);
    end

  // pulse-width monitors for the minimum-hold check
  logic [CW:0] p_len, s_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p_len <= '0;
      s_len <= '0;
    end else begin
      p_len <= !p_rst ? '0 : (p_len > (CW+1)'(HOLD_CYC)) ? p_len : p_len + 1'b1;
      s_len <= !s_rst ? '0 : (s_len > (CW+1)'(HOLD_CYC)) ? s_len : s_len + 1'b1;
    end

  a_r1_dev_both: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_req |=> p_rst && s_rst);
  a_r2_pnmi_both: assert property (@(posedge clk) disable iff (!rst_n)
    p_nmiwd_exp |=> p_rst && s_rst && flag_dev);
  a_r3_pwd_both: assert property (@(posedge clk) disable iff (!rst_n)
    p_wd_exp |=> p_rst && s_rst && flag_dev);
  a_r4_snmi_local: assert property (@(posedge clk) disable iff (!rst_n)
    (s_nmiwd_exp && !dev_evt && !p_rst) |=> s_rst && !p_rst);
  a_r5_nmi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    p_nmi |-> s_rst && flag_s_nmiwd && !p_rst);
  a_r6_wd_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wd_exp && !s_wd_rst_en && !s_nmiwd_exp && !dev_evt && !s_rst) |=> !s_rst);
  a_r7_rel_needs_p: assert property (@(posedge clk) disable iff (!rst_n)
    (s_armed && p_rst) |=> s_rst);
  a_r9_p_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(p_rst) |-> p_len >= (CW+1)'(HOLD_CYC));
  a_r9_s_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s_rst) |-> s_len >= (CW+1)'(HOLD_CYC));
  a_r11_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_evt && s_nmiwd_exp) |=> !p_nmi && s_rst);
  a_r12_rel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (s_release && !s_rst && !dev_evt && !s_nmiwd_exp && !s_wd_exp) |=> !s_rst);
endmodule

// File: tb/dcore_rst_scope_test.sv
module dcore_rst_scope_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev, pn, pw, sn, sw, en, rel, clr;
  logic p_rst, s_rst, p_nmi, f_dev, f_sn, f_sw;
  int   n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  dcore_rst_scope #(.HOLD_CYC(8)) uut (
    .clk(clk), .rst_n(rst_n), .dev_rst_req(dev), .p_nmiwd_exp(pn), .p_wd_exp(pw),
    .s_nmiwd_exp(sn), .s_wd_exp(sw), .s_wd_rst_en(en), .s_release(rel), .flag_clr(clr),
    .p_rst(p_rst), .s_rst(s_rst), .p_nmi(p_nmi),
    .flag_dev(f_dev), .flag_s_nmiwd(f_sn), .flag_s_wd(f_sw));

  // {dev,pn,sn,pw,sw,en,rel,clr} , idle cycles , {p_rst,s_rst,p_nmi,f_dev,f_sn,f_sw}
  localparam int NV = 29;
  localparam logic [21:0] VEC [NV] = '{
    {8'b00000010, 8'd0,  6'b000000},
    {8'b00000010, 8'd0,  6'b000000},
    {8'b00001000, 8'd0,  6'b000000},
    {8'b00001100, 8'd0,  6'b010001},
    {8'b00000000, 8'd6,  6'b010001},
    {8'b00000000, 8'd0,  6'b000001},
    {8'b00100000, 8'd0,  6'b011011},
    {8'b00000000, 8'd0,  6'b010011},
    {8'b00000000, 8'd6,  6'b000011},
    {8'b00000001, 8'd0,  6'b000000},
    {8'b10000000, 8'd0,  6'b110100},
    {8'b00000000, 8'd7,  6'b010100},
    {8'b00100000, 8'd0,  6'b011110},
    {8'b00000000, 8'd10, 6'b010110},
    {8'b00000010, 8'd0,  6'b000110},
    {8'b00000001, 8'd0,  6'b000000},
    {8'b10100000, 8'd0,  6'b110100},
    {8'b00000000, 8'd7,  6'b010100},
    {8'b00000010, 8'd0,  6'b000100},
    {8'b00010000, 8'd0,  6'b110100},
    {8'b00000000, 8'd7,  6'b010100},
    {8'b00000010, 8'd0,  6'b000100},
    {8'b01000000, 8'd0,  6'b110100},
    {8'b00000010, 8'd0,  6'b110100},
    {8'b00000000, 8'd6,  6'b010100},
    {8'b00001101, 8'd0,  6'b010001},
    {8'b00000000, 8'd8,  6'b010001},
    {8'b00000010, 8'd0,  6'b000001},
    {8'b10000001, 8'd0,  6'b110100}
  };

  function automatic string req_of(int i);
    case (i)
      0, 14, 18, 21, 27: return "R7";
      1:                 return "R12";
      2, 3:              return "R6";
      4:                 return "R9";
      5, 8, 12, 13, 26:  return "R8";
      6:                 return "R4";
      7:                 return "R5";
      9, 15, 25, 28:     return "R10";
      10:                return "R1";
      11, 20, 23, 24:    return "R7";
      16, 17:            return "R11";
      19:                return "R3";
      22:                return "R2";
      default:           return "R1";
    endcase
  endfunction

  task automatic check(string req, logic [5:0] exp);
    logic [5:0] act;
    act = {p_rst, s_rst, p_nmi, f_dev, f_sn, f_sw};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(logic [7:0] v);
    {dev, pn, sn, pw, sw, en, rel, clr} = v;
  endtask

  initial begin
    drive(8'h00);
    repeat (3) @(negedge clk);
    check("R9", 6'b110000);            // reset state
    rst_n = 1'b1;
    repeat (7) @(negedge clk);
    check("R9", 6'b110000);            // still within hold after release
    @(negedge clk);
    check("R7", 6'b010000);            // primary out, secondary held
    repeat (2) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][21:14]);
      @(negedge clk);
      drive(8'h00);
      repeat (int'(VEC[i][13:6])) @(negedge clk);
      check(req_of(i), VEC[i][5:0]);
    end
    // asynchronous assertion mid-cycle
    repeat (10) @(negedge clk);
    drive(8'b00000011);
    @(negedge clk);
    drive(8'h00);
    check("R10", 6'b000000);
    #1 rst_n = 1'b0;
    #0.5 check("R9", 6'b110000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R7", 6'b010000);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule